// File: doc/BRIEF.md
# Counted Loop Branch Execution Unit

This block executes the decrement-and-branch loop instructions of a 32-bit CISC core. A request carries an opcode byte, a signed 8-bit displacement, an address-size flag, the current count register, the zero flag and the address of the instruction that follows the loop instruction. The unit decrements the counter first. It then decides whether the branch is taken, using the decremented counter and a zero-flag test that the opcode selects. It returns the new count register value, a taken flag and the next instruction pointer.

The address-size flag sets the counter width. With 32-bit addressing the whole register counts. With 16-bit addressing only its low half counts, and the branch target is cut to 16 bits. The zero flag is only read, never written. An opcode outside the loop family is reported as unsupported, and its count and pointer are passed through unchanged.

Requests and results use a valid/ready handshake, and results are registered one stage deep.

Top module: `loop_branch_unit`

## Requirements
- R1: With `in_addr32`=1 and a loop opcode, `out_count` is `in_count` minus one over all 32 bits (0x00000000 wraps to 0xFFFFFFFF).
- R2: With `in_addr32`=0 and a loop opcode, bits 15:0 of `out_count` are bits 15:0 of `in_count` minus one, wrapping 0x0000 to 0xFFFF, and bits 31:16 are returned unchanged.
- R3: Opcode 0xE2 is taken exactly when the decremented counter of the selected width is nonzero. In 16-bit mode only the low 16 bits are tested.
- R4: Opcode 0xE1 is taken exactly when the decremented counter is nonzero and `in_zf`=1.
- R5: Opcode 0xE0 is taken exactly when the decremented counter is nonzero and `in_zf`=0.
- R6: When taken with `in_addr32`=1, `out_ip` = `in_next_ip` + the sign-extended `in_disp`, which covers -128 (0x80) to +127 (0x7F).
- R7: When taken with `in_addr32`=0, `out_ip` holds the low 16 bits of that sum, with bits 31:16 zero.
- R8: When not taken, `out_ip` equals `in_next_ip`.
- R9: For any opcode other than 0xE0, 0xE1 or 0xE2, `out_unsupported`=1, `out_taken`=0, `out_count`=`in_count` and `out_ip`=`in_next_ip`.
- R10: A request accepted on a clock edge (`in_valid` and `in_ready` both high) shows its result with `out_valid`=1 after that edge. Synchronous reset clears `out_valid`.
- R11: `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_opcode | input | 8 | Opcode byte |
| in_disp | input | 8 | Signed branch displacement |
| in_addr32 | input | 1 | 1: 32-bit address size, 0: 16-bit |
| in_count | input | 32 | Current count register |
| in_zf | input | 1 | Zero flag (read only) |
| in_next_ip | input | 32 | Address of the following instruction |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_count | output | 32 | Updated count register |
| out_taken | output | 1 | Branch taken |
| out_ip | output | 32 | Next instruction pointer |
| out_unsupported | output | 1 | Opcode is not a loop instruction |

## Verification
Every result comes from a single register stage. A request accepted on one rising edge has its count, taken flag, pointer and unsupported flag on the outputs after that same edge, so they can be read at the following falling edge. `in_ready` is combinational from `out_valid` and `out_ready`, so it is checked in the cycle in which it applies. The bench drives inputs on falling edges and updates its reference model on each rising edge. On the falling edge after that it compares the model with every output, which keeps stalls and back-to-back requests aligned to the one-cycle latency.

// File: rtl/loopbr_pkg.sv
package loopbr_pkg;

    localparam int WORD_W   = 32;
    localparam int NARROW_W = 16;
    localparam int DISP_W   = 8;
    localparam int OPC_W    = 8;

    localparam logic [OPC_W-1:0] OPC_LOOP_NZ = 8'hE0;
    localparam logic [OPC_W-1:0] OPC_LOOP_Z  = 8'hE1;
    localparam logic [OPC_W-1:0] OPC_LOOP    = 8'hE2;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_PLAIN,
        LK_WHILE_ZF,
        LK_WHILE_NOT_ZF
    } loop_kind_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [DISP_W-1:0] disp;
        logic              addr32;
        logic [WORD_W-1:0] count;
        logic              zf;
        logic [WORD_W-1:0] next_ip;
    } loop_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] count;
        logic              taken;
        logic [WORD_W-1:0] ip;
        logic              unsupported;
    } loop_rsp_t;

    function automatic logic [WORD_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(WORD_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic cond_met(input loop_kind_e k, input logic zf);
        case (k)
            LK_PLAIN:        return 1'b1;
            LK_WHILE_ZF:     return zf;
            LK_WHILE_NOT_ZF: return ~zf;
            default:         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lb_decode.sv
module lb_decode
    import loopbr_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output loop_kind_e       kind,
    output logic             supported
);
    always_comb begin
        case (opcode)
            OPC_LOOP:    kind = LK_PLAIN;
            OPC_LOOP_Z:  kind = LK_WHILE_ZF;
            OPC_LOOP_NZ: kind = LK_WHILE_NOT_ZF;
            default:     kind = LK_NONE;
        endcase
        supported = (kind != LK_NONE);
    end
endmodule

// File: rtl/lb_count.sv
module lb_count #(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input  logic [W-1:0] count,
    input  logic         narrow,
    output logic [W-1:0] next_count,
    output logic         is_zero
);
    logic [W-1:0]  full_dec;
    logic [NW-1:0] low_dec;

    always_comb begin
        full_dec = count - W'(1);
        low_dec  = count[NW-1:0] - NW'(1);
    end

    generate
        if (NW < W) begin : g_split
            always_comb begin
                next_count = narrow ? {count[W-1:NW], low_dec} : full_dec;
                is_zero    = narrow ? (low_dec == '0) : (full_dec == '0);
            end
        end else begin : g_flat
            always_comb begin
                next_count = full_dec;
                is_zero    = (full_dec == '0) && (narrow || !narrow);
            end
        end
    endgenerate
endmodule

// File: rtl/lb_target.sv
module lb_target
    import loopbr_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NW = NARROW_W
) (
    input  logic [W-1:0]      next_ip,
    input  logic [DISP_W-1:0] disp,
    input  logic              narrow,
    output logic [W-1:0]      target
);
    logic [W-1:0] sum;

    always_comb begin
        sum    = next_ip + sext_disp(disp);
        target = narrow ? {{(W-NW){1'b0}}, sum[NW-1:0]} : sum;
    end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import loopbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [DISP_W-1:0] in_disp,
    input  logic              in_addr32,
    input  logic [WORD_W-1:0] in_count,
    input  logic              in_zf,
    input  logic [WORD_W-1:0] in_next_ip,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_count,
    output logic              out_taken,
    output logic [WORD_W-1:0] out_ip,
    output logic              out_unsupported
);
    loop_req_t         req;
    loop_rsp_t         rsp_d, rsp_q;
    loop_kind_e        kind;
    logic              supported;
    logic [WORD_W-1:0] dec_count;
    logic              dec_zero;
    logic [WORD_W-1:0] target;
    logic              valid_q;
    logic              accept;

    always_comb begin
        req.opcode  = in_opcode;
        req.disp    = in_disp;
        req.addr32  = in_addr32;
        req.count   = in_count;
        req.zf      = in_zf;
        req.next_ip = in_next_ip;
    end

    lb_decode u_decode (
        .opcode    (req.opcode),
        .kind      (kind),
        .supported (supported)
    );

    lb_count #(.W(WORD_W), .NW(NARROW_W)) u_count (
        .count      (req.count),
        .narrow     (~req.addr32),
        .next_count (dec_count),
        .is_zero    (dec_zero)
    );

    lb_target #(.W(WORD_W), .NW(NARROW_W)) u_target (
        .next_ip (req.next_ip),
        .disp    (req.disp),
        .narrow  (~req.addr32),
        .target  (target)
    );

    always_comb begin
        rsp_d.unsupported = ~supported;
        rsp_d.taken       = supported && !dec_zero && cond_met(kind, req.zf);
        rsp_d.count       = supported ? dec_count : req.count;
        rsp_d.ip          = rsp_d.taken ? target : req.next_ip;
    end

    assign in_ready = ~valid_q | out_ready;
    assign accept   = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (accept) begin
            valid_q <= 1'b1;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            rsp_q <= rsp_d;
        end
    end

    assign out_valid       = valid_q;
    assign out_count       = rsp_q.count;
    assign out_taken       = rsp_q.taken;
    assign out_ip          = rsp_q.ip;
    assign out_unsupported = rsp_q.unsupported;
endmodule

// File: rtl/lb_checker.sv
module lb_checker
    import loopbr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [OPC_W-1:0]  in_opcode,
    input logic              in_addr32,
    input logic [15:0]       in_count_hi,
    input logic [WORD_W-1:0] in_next_ip,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_count,
    input logic              out_taken,
    input logic [WORD_W-1:0] out_ip,
    input logic              out_unsupported
);
    logic acc;
    logic loop_op;
    assign acc     = in_valid && in_ready;
    assign loop_op = (in_opcode == OPC_LOOP) || (in_opcode == OPC_LOOP_Z) ||
                     (in_opcode == OPC_LOOP_NZ);

    p_unsup_no_branch_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_unsupported |-> !out_taken);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_count) &&
                                    $stable(out_ip) && $stable(out_taken));

    p_accept_valid_r10: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    p_fallthrough_r8: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_taken || (out_ip == $past(in_next_ip)));

    p_upper_kept_r2: assert property (@(posedge clk) disable iff (rst)
        acc && !in_addr32 && loop_op |=> out_count[31:16] == $past(in_count_hi));

    p_narrow_ip_r7: assert property (@(posedge clk) disable iff (rst)
        acc && !in_addr32 |=> !out_taken || (out_ip[31:16] == 16'h0000));
endmodule

bind loop_branch_unit lb_checker u_lb_checker (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .in_opcode       (in_opcode),
    .in_addr32       (in_addr32),
    .in_count_hi     (in_count[31:16]),
    .in_next_ip      (in_next_ip),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_count       (out_count),
    .out_taken       (out_taken),
    .out_ip          (out_ip),
    .out_unsupported (out_unsupported)
);

// File: tb/test_loop_branch_unit.sv
`timescale 1ns/1ps
module test_loop_branch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_opcode = 8'h00;
    logic [7:0]  in_disp = 8'h00;
    logic        in_addr32 = 1'b1;
    logic [31:0] in_count = 32'h0;
    logic        in_zf = 1'b0;
    logic [31:0] in_next_ip = 32'h0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_count;
    logic        out_taken;
    logic [31:0] out_ip;
    logic        out_unsupported;

    int errors = 0;
    int checks = 0;

    bit          m_valid = 0;
    logic [31:0] m_count, m_ip;
    bit          m_taken, m_unsup;
    string       m_tag = "";
    string       cur_tag = "";

    always #2 clk = ~clk;

    loop_branch_unit i_loop_branch_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_disp(in_disp), .in_addr32(in_addr32),
        .in_count(in_count), .in_zf(in_zf), .in_next_ip(in_next_ip),
        .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
        .out_taken(out_taken), .out_ip(out_ip), .out_unsupported(out_unsupported)
    );

    task automatic check(string what, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference of one accepted request.
    task automatic model_accept();
        int unsigned cnt;
        int unsigned low;
        int signed   d;
        int unsigned tgt;
        bit          nz;
        bit          ok;
        bit          cond;
        d = int'($signed(in_disp));
        ok = (in_opcode == 8'hE0) || (in_opcode == 8'hE1) || (in_opcode == 8'hE2);
        if (in_addr32) begin
            cnt = in_count - 1;
            nz  = (cnt != 0);
        end else begin
            low = (in_count % 65536 + 65535) % 65536;
            cnt = (in_count / 65536) * 65536 + low;
            nz  = (low != 0);
        end
        tgt = in_next_ip + d;
        if (!in_addr32) tgt = tgt % 65536;
        cond = (in_opcode == 8'hE2) || (in_opcode == 8'hE1 && in_zf) ||
               (in_opcode == 8'hE0 && !in_zf);
        m_unsup = !ok;
        m_taken = ok && nz && cond;
        m_count = ok ? cnt : in_count;
        m_ip    = m_taken ? tgt : in_next_ip;
        m_tag   = cur_tag;
    endtask

    task automatic compare();
        check("in_ready", "R11", {31'b0, in_ready}, {31'b0, (!m_valid || out_ready)});
        check("out_valid", "R10", {31'b0, out_valid}, {31'b0, m_valid});
        if (m_valid) begin
            check("out_count", m_tag, out_count, m_count);
            check("out_taken", m_tag, {31'b0, out_taken}, {31'b0, m_taken});
            check("out_ip", m_tag, out_ip, m_ip);
            check("out_unsupported", m_tag, {31'b0, out_unsupported}, {31'b0, m_unsup});
        end
    endtask

    task automatic cycle();
        bit rdy;
        @(posedge clk);
        rdy = !m_valid || out_ready;
        if (rst) m_valid = 0;
        else if (in_valid && rdy) begin
            model_accept();
            m_valid = 1;
        end else if (out_ready) m_valid = 0;
        @(negedge clk);
        compare();
    endtask

    task automatic send(logic [7:0] op, logic [7:0] d, logic a32, logic [31:0] c,
                        logic z, logic [31:0] ip, string tag);
        in_opcode = op; in_disp = d; in_addr32 = a32; in_count = c;
        in_zf = z; in_next_ip = ip; cur_tag = tag; in_valid = 1'b1;
        cycle();
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        cycle(); cycle();
        check("reset out_valid", "R10", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        cycle();
        // R1 R3 R6: plain loop, 32-bit, taken forward
        send(8'hE2, 8'h10, 1'b1, 32'd5, 1'b0, 32'h0000_1000, "R1/R3/R6");
        // R3 R8: reaches zero, falls through
        send(8'hE2, 8'h10, 1'b1, 32'd1, 1'b0, 32'h0000_1000, "R3/R8");
        // R1: wrap from zero in 32-bit mode
        send(8'hE2, 8'hF0, 1'b1, 32'h0, 1'b0, 32'h0000_1000, "R1");
        // R2 R7: 16-bit wrap, upper kept, target truncated
        send(8'hE2, 8'h20, 1'b0, 32'hABCD_0000, 1'b0, 32'h0001_FFF0, "R2/R7");
        // R3: 16-bit low half zero but upper nonzero -> not taken
        send(8'hE2, 8'h20, 1'b0, 32'h0001_0001, 1'b0, 32'h0003_0040, "R3/R2");
        // R4: while-zero variants
        send(8'hE1, 8'hFC, 1'b1, 32'd3, 1'b1, 32'h0000_2000, "R4");
        send(8'hE1, 8'hFC, 1'b1, 32'd3, 1'b0, 32'h0000_2000, "R4");
        send(8'hE1, 8'hFC, 1'b1, 32'd1, 1'b1, 32'h0000_2000, "R4");
        // R5: while-not-zero variants
        send(8'hE0, 8'h08, 1'b1, 32'd3, 1'b0, 32'h0000_3000, "R5");
        send(8'hE0, 8'h08, 1'b1, 32'd3, 1'b1, 32'h0000_3000, "R5");
        send(8'hE0, 8'h08, 1'b0, 32'h1234_0002, 1'b0, 32'h0000_3000, "R5/R2");
        // R6: displacement extremes
        send(8'hE2, 8'h80, 1'b1, 32'd9, 1'b0, 32'h0000_2000, "R6");
        send(8'hE2, 8'h7F, 1'b1, 32'd9, 1'b0, 32'h0000_2000, "R6");
        // R7: 16-bit backward wrap below zero
        send(8'hE2, 8'h80, 1'b0, 32'd9, 1'b0, 32'hFFFF_0010, "R7");
        // R9: unsupported opcodes pass through
        send(8'hE3, 8'h10, 1'b1, 32'd7, 1'b1, 32'h0000_4000, "R9");
        send(8'h90, 8'h10, 1'b0, 32'h0000_0001, 1'b0, 32'h0000_4000, "R9");
        // R11: stall holds result, second request waits
        in_opcode = 8'hE2; in_disp = 8'h04; in_addr32 = 1'b1; in_count = 32'd2;
        in_zf = 1'b0; in_next_ip = 32'h0000_5000; cur_tag = "R11"; in_valid = 1'b1;
        cycle();
        out_ready = 1'b0;
        in_count = 32'd50; in_next_ip = 32'h0000_6000; cur_tag = "R11/R10";
        cycle(); cycle(); cycle();
        out_ready = 1'b1;
        cycle();
        in_valid = 1'b0;
        cycle(); cycle();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule